// File: doc/BRIEF.md
# Free-Running Cycle Counter with Coherent Half-Word Read

This block keeps a 32-bit count of reference clock cycles. It starts from zero on reset, adds one on every clock edge, and wraps past its maximum back to zero. Software reads the count over a 16-bit register bus. The count is wider than the bus, so reading the low half-word copies the whole live count into a holding register. A later read of the high half-word returns the upper part of that copy, so the two halves belong to the same instant even though the counter kept moving between the two accesses.

The host side is a synchronous read strobe, a half-word select and a registered 16-bit read-data output with a valid flag. A write strobe with write data and a two-bit power-state code also come into the block. Neither may change the count or the held copy. The counter is read-only, and it runs the same way in every power state.

The count width and the bus width are parameters, and the count is always two bus words wide. The reference clock is the block clock.

Top module: `frc_split_read`

## Requirements
- R1: While `rst` is high at a clock edge, the count and the holding register go to zero and `rd_valid` and `rd_data` go low at that edge. The first low-half read after reset is released returns 0.
- R2: Outside reset, the count rises by exactly one on every clock edge. Two low-half reads issued N cycles apart return values that differ by N (modulo 2^16).
- R3: When the count is at its maximum (all ones), the next edge sets it to zero and counting continues. With `CNT_W`=8 and `BUS_W`=4, a low read at count 0xFF returns 0xF and a low read two cycles later returns 0x1.
- R4: A strobe with `rd_hi`=0 (the low half) returns the live count bits [BUS_W-1:0] on `rd_data` in the next cycle. The same strobe copies the full live count into the holding register.
- R5: A strobe with `rd_hi`=1 (the high half) returns bits [CNT_W-1:BUS_W] of the holding register in the next cycle. It never returns the live count, and it does not change the holding register.
- R6: A high-half read made after reset with no low-half read before it returns 0.
- R7: `rd_valid` is high in exactly the cycle after each read strobe. `rd_data` keeps its value until the next strobe.
- R8: `wr_stb` and `wr_data` have no effect on the count, the holding register or the read outputs.
- R9: `pwr_state` (0 = full power, 1 and 2 = reduced power states) has no effect on counting or on reads.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference clock; the count advances on each rising edge |
| rst | input | 1 | Synchronous active-high reset |
| rd_stb | input | 1 | Read strobe, one cycle per access |
| rd_hi | input | 1 | Half-word select: 0 = low half (takes the snapshot), 1 = high half |
| wr_stb | input | 1 | Write strobe; ignored by this read-only register |
| wr_data | input | BUS_W | Write data; ignored |
| pwr_state | input | 2 | Power state code; ignored by the counter |
| rd_data | output | BUS_W | Registered read data |
| rd_valid | output | 1 | High in the cycle after a read strobe |

## Verification
The hardest case to reach is a low-half read made just before a carry into the upper half, followed some cycles later by a high-half read. A coherence fault only shows up there, because the live upper half has moved on by then. The bench waits until its own model of the count reaches 0xFFFE in the low half, issues the low read at that point and delays the high read by several cycles. The expected upper half then differs from the live one. The wrap is reached through a second instance with an 8-bit count, which makes the rollover reachable in a few hundred cycles.

// File: rtl/frc_pkg.sv
package frc_pkg;
  typedef enum logic {
    HALF_LO = 1'b0,
    HALF_HI = 1'b1
  } half_sel_e;

  typedef enum logic [1:0] {
    PWR_FULL  = 2'd0,
    PWR_LOW1  = 2'd1,
    PWR_LOW2  = 2'd2,
    PWR_RSVD  = 2'd3
  } pwr_state_e;
endpackage

// File: rtl/frc_counter.sv
module frc_counter #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  output logic [CNT_W-1:0] count
);
  localparam logic [CNT_W-1:0] ONE = {{(CNT_W-1){1'b0}}, 1'b1};

  logic [CNT_W-1:0] count_q;

  always_ff @(posedge clk) begin
    if (rst) count_q <= '0;
    else     count_q <= count_q + ONE;
  end

  assign count = count_q;
endmodule

// File: rtl/frc_holding.sv
module frc_holding #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             capture,
  input  logic [CNT_W-1:0] live,
  output logic [CNT_W-1:0] held
);
  logic [CNT_W-1:0] held_q;

  always_ff @(posedge clk) begin
    if (rst)          held_q <= '0;
    else if (capture) held_q <= live;
  end

  assign held = held_q;
endmodule

// File: rtl/frc_read_port.sv
module frc_read_port
  import frc_pkg::*;
#(
  parameter int CNT_W = 32,
  parameter int BUS_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             rd_stb,
  input  half_sel_e        half,
  input  logic [CNT_W-1:0] live,
  input  logic [CNT_W-1:0] held,
  output logic [BUS_W-1:0] rd_data,
  output logic             rd_valid
);
  localparam int HI_LSB = BUS_W;

  logic [BUS_W-1:0] sel_word;

  always_comb begin
    if (half == HALF_HI) sel_word = held[CNT_W-1:HI_LSB];
    else                 sel_word = live[BUS_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_data  <= '0;
      rd_valid <= 1'b0;
    end else begin
      rd_valid <= rd_stb;
      if (rd_stb) rd_data <= sel_word;
    end
  end
endmodule

// File: rtl/frc_split_read.sv
module frc_split_read
  import frc_pkg::*;
#(
  parameter int CNT_W = 32,
  parameter int BUS_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             rd_stb,
  input  logic             rd_hi,
  input  logic             wr_stb,
  input  logic [BUS_W-1:0] wr_data,
  input  logic [1:0]       pwr_state,
  output logic [BUS_W-1:0] rd_data,
  output logic             rd_valid
);
  localparam int HALVES = CNT_W / BUS_W;

  initial begin
    if (HALVES != 2 || CNT_W != 2 * BUS_W)
      $error("frc_split_read: CNT_W must be exactly twice BUS_W");
  end

  logic [CNT_W-1:0] live_cnt;
  logic [CNT_W-1:0] snap_q;
  half_sel_e        half;
  logic             take_snap;

  assign half      = half_sel_e'(rd_hi);
  assign take_snap = rd_stb && (half == HALF_LO);

  frc_counter #(.CNT_W(CNT_W)) counter_i (
    .clk   (clk),
    .rst   (rst),
    .count (live_cnt)
  );

  frc_holding #(.CNT_W(CNT_W)) holding_i (
    .clk     (clk),
    .rst     (rst),
    .capture (take_snap),
    .live    (live_cnt),
    .held    (snap_q)
  );

  frc_read_port #(.CNT_W(CNT_W), .BUS_W(BUS_W)) port_i (
    .clk      (clk),
    .rst      (rst),
    .rd_stb   (rd_stb),
    .half     (half),
    .live     (live_cnt),
    .held     (snap_q),
    .rd_data  (rd_data),
    .rd_valid (rd_valid)
  );
endmodule

// File: rtl/frc_split_read_chk.sv
module frc_split_read_chk #(
  parameter int CNT_W = 32,
  parameter int BUS_W = 16
) (
  input logic             clk,
  input logic             rst,
  input logic             rd_stb,
  input logic             rd_hi,
  input logic             wr_stb,
  input logic [BUS_W-1:0] wr_data,
  input logic [1:0]       pwr_state,
  input logic [BUS_W-1:0] rd_data,
  input logic             rd_valid,
  input logic [CNT_W-1:0] cnt,
  input logic [CNT_W-1:0] snap
);
  localparam logic [CNT_W-1:0] ONE = {{(CNT_W-1){1'b0}}, 1'b1};

  AST_RESET_CLEARS: assert property (@(posedge clk)
    rst |=> (cnt == '0) && (snap == '0) && !rd_valid && (rd_data == '0)); // R1

  AST_STEP_ONE: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (cnt == $past(cnt) + ONE)); // R2

  AST_WRAP_ZERO: assert property (@(posedge clk) disable iff (rst)
    (cnt == '1) |=> (cnt == '0)); // R3

  AST_LO_SNAPSHOT: assert property (@(posedge clk) disable iff (rst)
    (rd_stb && !rd_hi) |=> (snap == $past(cnt)) && (rd_data == $past(cnt[BUS_W-1:0]))); // R4

  AST_HI_FROM_HELD: assert property (@(posedge clk) disable iff (rst)
    (rd_stb && rd_hi) |=> (rd_data == $past(snap[CNT_W-1:BUS_W])) && $stable(snap)); // R5

  AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (rd_valid == $past(rd_stb))); // R7

  AST_DATA_HOLDS: assert property (@(posedge clk) disable iff (rst)
    !rd_stb |=> $stable(rd_data)); // R7

  AST_WRITE_IGNORED: assert property (@(posedge clk) disable iff (rst)
    (wr_stb && (wr_data != snap[BUS_W-1:0]) && !rd_stb) |=> $stable(snap) && $stable(rd_data)); // R8

  AST_PWR_NO_STALL: assert property (@(posedge clk) disable iff (rst)
    (pwr_state != 2'd0) |=> (cnt == $past(cnt) + ONE)); // R9
endmodule

bind frc_split_read frc_split_read_chk #(.CNT_W(CNT_W), .BUS_W(BUS_W)) chk_i (
  .clk       (clk),
  .rst       (rst),
  .rd_stb    (rd_stb),
  .rd_hi     (rd_hi),
  .wr_stb    (wr_stb),
  .wr_data   (wr_data),
  .pwr_state (pwr_state),
  .rd_data   (rd_data),
  .rd_valid  (rd_valid),
  .cnt       (live_cnt),
  .snap      (snap_q)
);

// File: tb/frc_split_read_tb.sv
module frc_split_read_tb_top;
  localparam int CNT_W   = 32;
  localparam int BUS_W   = 16;
  localparam int S_CNT_W = 8;
  localparam int S_BUS_W = 4;
  localparam int NVEC    = 12;
  localparam int WATCHDOG_CYCLES = 190000;

  // vector: idle[7:0] rd hi wr wdat[15:0] pwr[1:0]
  typedef struct packed {
    logic [7:0]  idle;
    logic        rd;
    logic        hi;
    logic        wr;
    logic [15:0] wdat;
    logic [1:0]  pwr;
  } vec_t;

  localparam vec_t VEC [NVEC] = '{
    '{8'd0,  1'b1, 1'b1, 1'b0, 16'h0000, 2'd0},  // R6 hi before any lo
    '{8'd3,  1'b1, 1'b0, 1'b0, 16'h0000, 2'd0},  // R4
    '{8'd5,  1'b1, 1'b1, 1'b0, 16'h0000, 2'd0},  // R5
    '{8'd0,  1'b0, 1'b0, 1'b1, 16'hBEEF, 2'd0},  // R8 write
    '{8'd0,  1'b1, 1'b1, 1'b1, 16'h1234, 2'd0},  // R8 write + hi
    '{8'd9,  1'b1, 1'b0, 1'b0, 16'h0000, 2'd1},  // R9
    '{8'd20, 1'b1, 1'b0, 1'b0, 16'h0000, 2'd2},  // R2 R9
    '{8'd0,  1'b1, 1'b0, 1'b0, 16'h0000, 2'd0},  // R2 back to back
    '{8'd1,  1'b1, 1'b1, 1'b0, 16'h0000, 2'd3},  // R5
    '{8'd40, 1'b0, 1'b0, 1'b1, 16'hFFFF, 2'd2},  // R8
    '{8'd0,  1'b1, 1'b1, 1'b0, 16'h0000, 2'd0},  // R8 held unchanged
    '{8'd7,  1'b1, 1'b0, 1'b1, 16'h5555, 2'd1}   // R4 R8
  };

  logic               clk = 1'b0;
  logic               rst = 1'b1;
  logic               rd_stb = 1'b0;
  logic               rd_hi = 1'b0;
  logic               wr_stb = 1'b0;
  logic [BUS_W-1:0]   wr_data = '0;
  logic [1:0]         pwr_state = 2'd0;
  logic [BUS_W-1:0]   rd_data;
  logic               rd_valid;
  logic [S_BUS_W-1:0] s_rd_data;
  logic               s_rd_valid;

  int n_vec = 0;
  int n_bad = 0;
  int cycles = 0;
  bit done = 1'b0;

  logic [CNT_W-1:0] model = '0;
  logic [CNT_W-1:0] snap_m = '0;

  always #10 clk = ~clk;  // 50 MHz

  frc_split_read #(.CNT_W(CNT_W), .BUS_W(BUS_W)) dut_i (
    .clk(clk), .rst(rst), .rd_stb(rd_stb), .rd_hi(rd_hi), .wr_stb(wr_stb),
    .wr_data(wr_data), .pwr_state(pwr_state), .rd_data(rd_data), .rd_valid(rd_valid)
  );

  frc_split_read #(.CNT_W(S_CNT_W), .BUS_W(S_BUS_W)) small_i (
    .clk(clk), .rst(rst), .rd_stb(rd_stb), .rd_hi(rd_hi), .wr_stb(wr_stb),
    .wr_data(wr_data[S_BUS_W-1:0]), .pwr_state(pwr_state),
    .rd_data(s_rd_data), .rd_valid(s_rd_valid)
  );

  always @(posedge clk) begin
    model  <= rst ? '0 : model + 1;
    cycles <= cycles + 1;
  end

  always @(negedge clk) begin
    if (!done && cycles > WATCHDOG_CYCLES) begin
      done = 1'b1;
      n_bad++;
      $display("FAIL watchdog: actual %0d cycles expected < %0d", cycles, WATCHDOG_CYCLES);
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  // one access at the current negedge; checks both instances afterwards
  task automatic access(input string req, input logic rd, input logic hi,
                        input logic wr, input logic [15:0] wd, input logic [1:0] pw);
    logic [BUS_W-1:0]   exp_d;
    logic [S_BUS_W-1:0] exp_s;
    logic [BUS_W-1:0]   prev_d;
    logic [S_BUS_W-1:0] prev_s;
    prev_d = rd_data;
    prev_s = s_rd_data;
    rd_stb = rd; rd_hi = hi; wr_stb = wr; wr_data = wd; pwr_state = pw;
    if (rd && !hi) begin
      snap_m = model;
      exp_d  = model[BUS_W-1:0];
      exp_s  = model[S_BUS_W-1:0];
    end else if (rd) begin
      exp_d = snap_m[CNT_W-1:BUS_W];
      exp_s = snap_m[S_CNT_W-1:S_BUS_W];
    end else begin
      exp_d = prev_d;
      exp_s = prev_s;
    end
    @(negedge clk);
    rd_stb = 1'b0; wr_stb = 1'b0; wr_data = '0;
    check({req, " data"},  32'(rd_data),   32'(exp_d));
    check({req, " small"}, 32'(s_rd_data), 32'(exp_s));
    check("R7 valid", 32'(rd_valid), 32'(rd));
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic do_reset;
    rst = 1'b1;
    idle(3);
    rst = 1'b0;
    snap_m = '0;
  endtask

  initial begin
    idle(1);
    do_reset();
    // R1: reset state
    check("R1 rd_data",  32'(rd_data),  32'd0);
    check("R1 rd_valid", 32'(rd_valid), 32'd0);

    // vector walk
    for (int v = 0; v < NVEC; v++) begin
      idle(int'(VEC[v].idle));
      access("R4/R5/R8/R9 vec", VEC[v].rd, VEC[v].hi, VEC[v].wr, VEC[v].wdat, VEC[v].pwr);
    end

    // R2: spacing between two low reads
    begin
      logic [BUS_W-1:0] a;
      access("R2 first", 1'b1, 1'b0, 1'b0, 16'h0, 2'd0);
      a = rd_data;
      idle(12);
      access("R2 second", 1'b1, 1'b0, 1'b0, 16'h0, 2'd2);
      check("R2 delta", 32'(rd_data - a), 32'd13);
    end

    // R1: reset mid-run, then R6 hi without lo, then first lo reads zero
    do_reset();
    access("R6 hi after reset", 1'b1, 1'b1, 1'b0, 16'h0, 2'd0);
    check("R6 value", 32'(rd_data), 32'd0);
    do_reset();
    access("R1 first lo", 1'b1, 1'b0, 1'b0, 16'h0, 2'd0);
    check("R1 zero", 32'(rd_data), 32'd0);

    // R3: small instance wraps (count 0xFF -> 0x00)
    while (model[S_CNT_W-1:0] != 8'hFF) @(negedge clk);
    access("R3 lo at max", 1'b1, 1'b0, 1'b0, 16'h0, 2'd1);
    check("R3 small max", 32'(s_rd_data), 32'hF);
    access("R3 hi at max", 1'b1, 1'b1, 1'b0, 16'h0, 2'd0);
    check("R3 small hi", 32'(s_rd_data), 32'hF);
    access("R3 lo after wrap", 1'b1, 1'b0, 1'b0, 16'h0, 2'd0);
    check("R3 small wrapped", 32'(s_rd_data), 32'h1);

    // R5: coherence across the carry into the upper half
    while (model[BUS_W-1:0] != 16'hFFFE) @(negedge clk);
    access("R5 lo before carry", 1'b1, 1'b0, 1'b0, 16'h0, 2'd0);
    check("R5 lo value", 32'(rd_data), 32'hFFFE);
    idle(6);
    access("R5 hi after carry", 1'b1, 1'b1, 1'b0, 16'h0, 2'd2);
    check("R5 held upper", 32'(rd_data), 32'd0);

    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end
endmodule